// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the configuration registers of one bus function, seen from the target side. A bus transaction engine outside the block turns configuration cycles into single-cycle read and write strobes. Each strobe carries a DWORD index (0 to 63, covering 256 bytes) and four byte-lane enables. The lower 16 DWORDs hold the standard header. The upper 48 DWORDs are device-specific, and a parameter sets how many of them are backed by storage.

The identification values (vendor, device, revision, class code, subsystem IDs), the header layout code, the multi-function flag and the capability options are elaboration-time parameters and cannot be written. The rest of the device drives one-cycle event pulses (parity problems, aborts, system error) that set sticky status bits. Software clears those bits by writing ones to them. Decoded command bits leave the block as enable outputs that gate I/O decode, memory decode, bus mastering and error reporting.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset the command register is 0, all event status bits are 0, all device-specific storage is 0 and every enable output is low.
- R2: DWORD 0 reads {device ID, vendor ID}, DWORD 2 reads {class code[23:0], revision ID} and DWORD 11 reads {subsystem ID, subsystem vendor ID}. Writes to these DWORDs change nothing.
- R3: DWORD 3 reads zero except in bits 23:16, the header-type byte. Bit 23 is 1 exactly when the function belongs to a multi-function device, and bits 22:16 carry the layout code.
- R4: Command bit 0 drives `en_io`, bit 1 `en_mem`, bit 2 `en_master`, bit 6 `en_perr_resp` and bit 8 `en_serr`. All other command bits read 0. The command register is the low half of DWORD 1.
- R5: On a write, each byte lane changes only when its enable bit is set. Lane n covers wdata bits 8n+7:8n.
- R6: A one-cycle event pulse sets its status bit (status = high half of DWORD 1), and the bit stays set. The positions are: master data parity error at bit 8, signaled target abort at 11, received target abort at 12, received master abort at 13, signaled system error at 14, detected parity error at 15.
- R7: Writing 1 to a set event status bit (with byte lane 3 enabled) clears it. Writing 0 leaves it unchanged.
- R8: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: Status bit 4 is read-only and equals the capability-list option. When that option is on, DWORD 13 bits 7:0 give the capability pointer. Status bit 5 is read-only and equals the 66 MHz option.
- R10: DWORDs 16 up to 16+USER_DWORDS-1 are read/write storage. Every other location not named in R2 to R9 reads 0 and ignores writes.
- R11: Read data and `cfg_rvalid` appear in the cycle after `cfg_rd` is sampled. `cfg_rvalid` is low in the cycle after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | DWORD index within the 256-byte space |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid |
| ev_mstr_dpar | input | 1 | Master data parity error pulse |
| ev_tabt_sent | input | 1 | Signaled target abort pulse |
| ev_tabt_rcvd | input | 1 | Received target abort pulse |
| ev_mabt_rcvd | input | 1 | Received master abort pulse |
| ev_serr_sent | input | 1 | Signaled system error pulse |
| ev_par_det | input | 1 | Detected parity error pulse |
| en_io | output | 1 | I/O space response enable |
| en_mem | output | 1 | Memory space response enable |
| en_master | output | 1 | Bus master enable |
| en_perr_resp | output | 1 | Parity error response enable |
| en_serr | output | 1 | System error reporting enable |

## Verification
All-ones writes to the read-only identification and unimplemented DWORDs show that the write decode cannot reach them. Partial byte-enable patterns on the command DWORD and on device-specific storage separate lane gating from whole-DWORD writes. A burst of every event followed by selective write-1 clears, a write of zeros and a write with lane 3 disabled shows each status bit keeping its own position and clear rule. An event that coincides with its own clear, followed by a mid-run reset, separates the priority rule and the reset state from plain clearing.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   // DWORD indices that have a fixed meaning
   localparam int DW_ID      = 0;
   localparam int DW_CMDSTS  = 1;
   localparam int DW_CLASS   = 2;
   localparam int DW_HDR     = 3;
   localparam int DW_SUBSYS  = 11;
   localparam int DW_CAPPTR  = 13;
   localparam int DW_USER    = 16;
   localparam int DW_TOTAL   = 64;
   localparam int DW_MAXUSER = DW_TOTAL - DW_USER;

   // command bits with a function
   localparam int CMD_IO     = 0;
   localparam int CMD_MEM    = 1;
   localparam int CMD_MASTER = 2;
   localparam int CMD_PERR   = 6;
   localparam int CMD_SERR   = 8;
   localparam logic [15:0] CMD_WMASK = 16'h0147;

   // event status bits, in event-port order
   localparam int N_EVT = 6;
   localparam int STS_POS [N_EVT] = '{8, 11, 12, 13, 14, 15};
   localparam int STS_CAP  = 4;
   localparam int STS_66M  = 5;

   function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
      logic [31:0] r;
      for (int l = 0; l < 4; l++)
         r[l*8 +: 8] = be[l] ? new_v[l*8 +: 8] : old_v[l*8 +: 8];
      return r;
   endfunction
endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
   import cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [1:0]  be,
   input  logic [15:0] wdata,
   output logic [15:0] cmd
);
   logic [15:0] cmd_q;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmd_q[l*8 +: 8] <= '0;
         else if (wr && be[l])
            cmd_q[l*8 +: 8] <= wdata[l*8 +: 8] & CMD_WMASK[l*8 +: 8];
      end
   end

   assign cmd = cmd_q;

   // R5
   cmd_lane0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr && be[0])) |=> $stable(cmd[7:0]));
   // R5
   cmd_lane1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr && be[1])) |=> $stable(cmd[15:8]));
   // R4
   cmd_io_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && be[0]) |=> (cmd[CMD_IO] == $past(wdata[CMD_IO])));
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
   import cfg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt,
   input  logic [N_EVT-1:0] clr,
   output logic [15:0]      sts
);
   logic [N_EVT-1:0] hit_q;

   for (genvar i = 0; i < N_EVT; i++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hit_q[i] <= 1'b0;
         else
            hit_q[i] <= (hit_q[i] & ~clr[i]) | evt[i];
      end

      // R6 R8
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> hit_q[i]);
      // R7
      w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_q[i] && !clr[i]) |=> hit_q[i]);
      // R7
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !evt[i]) |=> !hit_q[i]);
   end

   always_comb begin
      sts = '0;
      for (int i = 0; i < N_EVT; i++)
         sts[STS_POS[i]] = hit_q[i];
   end
endmodule

// File: rtl/cfg_user_ram.sv
module cfg_user_ram
   import cfg_pkg::*;
#(
   parameter int DWORDS = 16
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [5:0]  off,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);
   logic [31:0] mem [DWORDS];

   for (genvar d = 0; d < DWORDS; d++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[d] <= '0;
         else if (wr && off == 6'(d))
            mem[d] <= lane_merge(mem[d], wdata, be);
      end
   end

   always_comb begin
      rdata = '0;
      for (int d = 0; d < DWORDS; d++)
         if (off == 6'(d)) rdata = mem[d];
   end
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
   import cfg_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID     = 16'h1B2C,
   parameter logic [15:0] DEVICE_ID     = 16'h4D01,
   parameter logic [7:0]  REVISION      = 8'h03,
   parameter logic [23:0] CLASS_CODE    = 24'h058000,
   parameter logic [15:0] SUBSYS_VENDOR = 16'h1B2C,
   parameter logic [15:0] SUBSYS_ID     = 16'h0A11,
   parameter bit          MULTI_FUNC    = 1'b1,
   parameter logic [6:0]  HDR_LAYOUT    = 7'h00,
   parameter bit          HAS_CAP       = 1'b1,
   parameter logic [7:0]  CAP_PTR       = 8'h40,
   parameter bit          CAP_66MHZ     = 1'b1,
   parameter int          USER_DWORDS   = 16
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic        cfg_rd,
   input  logic [5:0]  cfg_addr,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic        cfg_rvalid,
   input  logic        ev_mstr_dpar,
   input  logic        ev_tabt_sent,
   input  logic        ev_tabt_rcvd,
   input  logic        ev_mabt_rcvd,
   input  logic        ev_serr_sent,
   input  logic        ev_par_det,
   output logic        en_io,
   output logic        en_mem,
   output logic        en_master,
   output logic        en_perr_resp,
   output logic        en_serr
);
   localparam logic [6:0]  USER_END = 7'(DW_USER + USER_DWORDS);
   localparam logic [31:0] ID_WORD  = {DEVICE_ID, VENDOR_ID};
   localparam logic [31:0] CLS_WORD = {CLASS_CODE, REVISION};
   localparam logic [31:0] SUB_WORD = {SUBSYS_ID, SUBSYS_VENDOR};
   localparam logic [31:0] HDR_WORD = {8'h00, MULTI_FUNC, HDR_LAYOUT, 16'h0000};
   localparam logic [31:0] CAP_WORD = HAS_CAP ? {24'h0, CAP_PTR} : 32'h0;

   // elaboration-time parameter checks
   if (USER_DWORDS < 0 || USER_DWORDS > DW_MAXUSER) begin : g_bad_user
      $error("USER_DWORDS must lie in 0..48");
   end
   if (HAS_CAP && (CAP_PTR < 8'h40 || CAP_PTR[1:0] != 2'b00)) begin : g_bad_cap
      $error("CAP_PTR must be DWORD aligned and point past the header");
   end

   // address decode
   logic sel_cmdsts, in_user;
   assign sel_cmdsts = (cfg_addr == 6'(DW_CMDSTS));
   assign in_user    = ({1'b0, cfg_addr} >= 7'(DW_USER)) && ({1'b0, cfg_addr} < USER_END);

   // command register
   logic [15:0] cmd;
   cfg_cmd_reg u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr && sel_cmdsts),
      .be    (cfg_be[1:0]),
      .wdata (cfg_wdata[15:0]),
      .cmd   (cmd)
   );

   // event status bits
   logic [N_EVT-1:0] evt_vec, clr_vec;
   assign evt_vec = {ev_par_det, ev_serr_sent, ev_mabt_rcvd,
                     ev_tabt_rcvd, ev_tabt_sent, ev_mstr_dpar};
   for (genvar i = 0; i < N_EVT; i++) begin : g_clr
      assign clr_vec[i] = cfg_wr && sel_cmdsts && cfg_be[2 + STS_POS[i]/8]
                          && cfg_wdata[16 + STS_POS[i]];
   end

   logic [15:0] sts_evt, status;
   cfg_status_reg u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_vec),
      .clr   (clr_vec),
      .sts   (sts_evt)
   );

   always_comb begin
      status          = sts_evt;
      status[STS_CAP] = HAS_CAP;
      status[STS_66M] = CAP_66MHZ;
   end

   // device-specific storage
   logic [31:0] user_rd;
   logic [5:0]  user_off;
   assign user_off = cfg_addr - 6'(DW_USER);
   if (USER_DWORDS > 0) begin : g_user
      cfg_user_ram #(.DWORDS(USER_DWORDS)) u_ram (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (cfg_wr && in_user),
         .off   (user_off),
         .be    (cfg_be),
         .wdata (cfg_wdata),
         .rdata (user_rd)
      );
   end else begin : g_nouser
      assign user_rd = '0;
   end

   // read mux and output register
   logic [31:0] rd_mux;
   always_comb begin
      unique case (cfg_addr)
         6'(DW_ID):     rd_mux = ID_WORD;
         6'(DW_CMDSTS): rd_mux = {status, cmd};
         6'(DW_CLASS):  rd_mux = CLS_WORD;
         6'(DW_HDR):    rd_mux = HDR_WORD;
         6'(DW_SUBSYS): rd_mux = SUB_WORD;
         6'(DW_CAPPTR): rd_mux = CAP_WORD;
         default:       rd_mux = in_user ? user_rd : 32'h0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rdata  <= '0;
         cfg_rvalid <= 1'b0;
      end else begin
         cfg_rvalid <= cfg_rd;
         if (cfg_rd) cfg_rdata <= rd_mux;
      end
   end

   assign en_io        = cmd[CMD_IO];
   assign en_mem       = cmd[CMD_MEM];
   assign en_master    = cmd[CMD_MASTER];
   assign en_perr_resp = cmd[CMD_PERR];
   assign en_serr      = cmd[CMD_SERR];

   // R11
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd |=> cfg_rvalid);
   // R11
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> !cfg_rvalid);
   // R2
   id_word_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_addr == 6'(DW_ID)) |=> (cfg_rdata == ID_WORD));
   // R3
   hdr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_addr == 6'(DW_HDR)) |=> (cfg_rdata[23] == MULTI_FUNC));
   // R9
   ro_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && sel_cmdsts) |=> (cfg_rdata[16+STS_CAP] == HAS_CAP
                                  && cfg_rdata[16+STS_66M] == CAP_66MHZ));
endmodule

// File: tb/tb_cfg_space_regs.sv
module tb_cfg_space_regs;
   localparam logic [15:0] T_VEN  = 16'h1B2C;
   localparam logic [15:0] T_DEV  = 16'h4D01;
   localparam logic [7:0]  T_REV  = 8'h03;
   localparam logic [23:0] T_CLS  = 24'h058000;
   localparam logic [15:0] T_SVEN = 16'h1B2C;
   localparam logic [15:0] T_SID  = 16'h0A11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_rd = 1'b0;
   logic [5:0] cfg_addr = '0;
   logic [3:0] cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic cfg_rvalid;
   logic ev_mstr_dpar = 0, ev_tabt_sent = 0, ev_tabt_rcvd = 0;
   logic ev_mabt_rcvd = 0, ev_serr_sent = 0, ev_par_det = 0;
   logic en_io, en_mem, en_master, en_perr_resp, en_serr;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q [$];
   string tag_q [$];

   always #2.5 clk = ~clk;

   cfg_space_regs #(
      .VENDOR_ID(T_VEN), .DEVICE_ID(T_DEV), .REVISION(T_REV),
      .CLASS_CODE(T_CLS), .SUBSYS_VENDOR(T_SVEN), .SUBSYS_ID(T_SID),
      .MULTI_FUNC(1'b1), .HDR_LAYOUT(7'h00), .HAS_CAP(1'b1),
      .CAP_PTR(8'h40), .CAP_66MHZ(1'b1), .USER_DWORDS(16)
   ) dut (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      cfg_rd = 1'b0;
   endtask

   // monitor: compares each returned read with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && cfg_rvalid) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: actual unexpected rvalid expected none");
         end else begin
            check(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
         end
      end
   end

   function automatic logic [31:0] enables();
      return {27'h0, en_serr, en_perr_resp, en_master, en_mem, en_io};
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 enables after reset", enables(), 32'h0);
      rd(6'd1, 32'h0030_0000, "R1 R9 cmd/status after reset");
      rd(6'd16, 32'h0, "R1 user storage after reset");
      rd(6'd0, {T_DEV, T_VEN}, "R2 id word");
      rd(6'd2, {T_CLS, T_REV}, "R2 class word");
      rd(6'd11, {T_SID, T_SVEN}, "R2 subsystem word");
      rd(6'd3, 32'h0080_0000, "R3 header type byte");
      rd(6'd13, 32'h0000_0040, "R9 capability pointer");
      // read-only words ignore writes
      wr(6'd0, 4'hF, 32'hFFFF_FFFF);
      wr(6'd3, 4'hF, 32'hFFFF_FFFF);
      rd(6'd0, {T_DEV, T_VEN}, "R2 id after write");
      rd(6'd3, 32'h0080_0000, "R3 header after write");
      // command register, low lane only
      wr(6'd1, 4'b0001, 32'h0000_FFFF);
      check("R4 enables low lane", enables(), 32'h0000_000F);
      rd(6'd1, 32'h0030_0047, "R4 command readback");
      wr(6'd1, 4'b0010, 32'h0000_FF00);
      check("R4 serr enable", enables(), 32'h0000_001F);
      // lane gating: lane0 data present but disabled
      wr(6'd1, 4'b0010, 32'h0000_00FF);
      check("R5 lane0 untouched", enables(), 32'h0000_000F);
      rd(6'd1, 32'h0030_0047, "R5 command after partial write");
      // events
      @(negedge clk);
      {ev_par_det, ev_serr_sent, ev_mabt_rcvd, ev_tabt_rcvd, ev_tabt_sent, ev_mstr_dpar} = 6'h3F;
      @(negedge clk);
      {ev_par_det, ev_serr_sent, ev_mabt_rcvd, ev_tabt_rcvd, ev_tabt_sent, ev_mstr_dpar} = 6'h00;
      rd(6'd1, 32'hF930_0047, "R6 all events set");
      wr(6'd1, 4'b1000, 32'h0900_0000);
      rd(6'd1, 32'hF030_0047, "R7 clear bits 8 and 11");
      wr(6'd1, 4'b1000, 32'h0000_0000);
      rd(6'd1, 32'hF030_0047, "R7 write of zeros keeps bits");
      wr(6'd1, 4'b0111, 32'hFFFF_0000);
      rd(6'd1, 32'hF030_0000, "R5 R7 lane3 disabled, command cleared");
      check("R4 enables cleared", enables(), 32'h0);
      // event and clear together
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 6'd1; cfg_be = 4'b1000; cfg_wdata = 32'hF000_0000;
      ev_par_det = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; ev_par_det = 1'b0;
      rd(6'd1, 32'h8030_0000, "R8 event beats clear");
      // device-specific storage and unimplemented space
      wr(6'd16, 4'hF, 32'hDEAD_BEEF);
      wr(6'd31, 4'b0101, 32'h1122_3344);
      wr(6'd32, 4'hF, 32'hFFFF_FFFF);
      wr(6'd5, 4'hF, 32'hFFFF_FFFF);
      rd(6'd16, 32'hDEAD_BEEF, "R10 user word 16");
      rd(6'd31, 32'h0022_0044, "R10 R5 user word 31 lanes");
      rd(6'd32, 32'h0, "R10 beyond storage reads zero");
      rd(6'd5, 32'h0, "R10 unimplemented header word");
      @(negedge clk);
      check("R11 rvalid idle", {31'h0, cfg_rvalid}, 32'h0);
      // reset in mid run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(6'd1, 32'h0030_0000, "R1 status and command after second reset");
      rd(6'd16, 32'h0, "R1 storage after second reset");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R11: actual %0d pending expected 0", exp_q.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule